// File: doc/BRIEF.md
# Block Stream Cipher Data Path with Tail Padding

This block turns a stream of 128-bit words into ciphertext or plaintext against a five-word running state that lives in a separate updater. Each word gets a keystream value mixed from three state words: word 1, word 4, and the AND of words 2 and 3. The result is registered for the consumer. In the same cycle the block sends the updater a word built from the plaintext and strobes it, so the next word sees the updated state.

A message ends with a word flagged last. If that word carries a nonzero byte count n (1 to 15), only its low n bytes count. The block zeroes the rest in the update word and in the result, and the byte-enable mask marks the valid bytes. A last word with count 0 is a full word.

A two-state controller tracks where the block is in a message. ST_IDLE means no message is open and ST_OPEN means one is in progress. The controller has three transitions:
- IDLE_TO_OPEN: a non-last word is accepted while idle.
- OPEN_TO_IDLE: a last word is accepted while open.
- STAY: any other case; a single-word message is accepted and stays in ST_IDLE.

The first result of each message is tagged.

Top module: `stream_crypt_path`

## Requirements
- R1: The keystream word is z = W1 ^ W4 ^ (W2 & W3), taken from the state inputs in the cycle the word is accepted.
- R2: When encrypting (`in_decrypt`=0), the result is the input word XOR z.
- R3: When encrypting, `upd_word` is the input plaintext.
- R4: When decrypting (`in_decrypt`=1), the result is the input word XOR z, which is the recovered plaintext.
- R5: When decrypting, `upd_word` is that recovered plaintext.
- R6: On a last word with count n from 1 to 15, bytes n..15 of both `upd_word` and `res_data` are zero. Byte i occupies bits 8i+7:8i.
- R7: `res_be` has its low n bits set on a partial last word and all 16 bits set on a full word.
- R8: A last word with count 0 is treated as full, with no padding.
- R9: `in_count` has no effect on a word that is not flagged last.
- R10: `in_ready` follows `upd_ready`. `upd_strobe` is high exactly when `in_valid` and `upd_ready` are both high.
- R11: Each accepted word gives exactly one result, with `res_valid` high in the cycle after acceptance. `res_valid` is low otherwise.
- R12: `res_first` marks the result of a word accepted in ST_IDLE. `res_last` copies the word's last flag. The controller moves IDLE_TO_OPEN on a non-last word and OPEN_TO_IDLE on a last word.
- R13: After reset, `res_valid` is low and the controller is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt |
| in_data | input | 128 | Input word, byte i at bits 8i+7:8i |
| in_count | input | 4 | Valid bytes of a last word, 0 = full |
| in_last | input | 1 | Word closes the message |
| st_w1 | input | 128 | State word 1 |
| st_w2 | input | 128 | State word 2 |
| st_w3 | input | 128 | State word 3 |
| st_w4 | input | 128 | State word 4 |
| upd_ready | input | 1 | Updater can absorb a word |
| upd_strobe | output | 1 | Update request |
| upd_word | output | 128 | Plaintext fed to the updater |
| res_valid | output | 1 | Result present |
| res_data | output | 128 | Result word, invalid bytes zero |
| res_be | output | 16 | Byte-enable of the result |
| res_first | output | 1 | Result starts a message |
| res_last | output | 1 | Result ends a message |

## Verification
The assertions assume the state words are stable while a word is offered, and that the updater applies a strobed word before the next accept. The bench meets this by driving a fresh set of state words together with each word. The assertions also assume `in_count` lies in 0 to 15, which its width guarantees. Random words, counts, modes and ready gaps are all drawn inside these limits, and directed cases cover counts 0, 1 and 15 and a non-last word carrying a count.

// File: rtl/scp_pkg.sv
package scp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } msg_state_t;
endpackage

// File: rtl/scp_keystream.sv
module scp_keystream #(
    parameter int W = 128
) (
    input  logic [W-1:0] w1,
    input  logic [W-1:0] w2,
    input  logic [W-1:0] w3,
    input  logic [W-1:0] w4,
    output logic [W-1:0] ks
);
    always_comb ks = w1 ^ w4 ^ (w2 & w3);
endmodule

// File: rtl/scp_tail_mask.sv
module scp_tail_mask #(
    parameter int BYTES = 16,
    localparam int CW = $clog2(BYTES),
    localparam int W = BYTES * 8
) (
    input  logic [CW-1:0] count,
    input  logic          last,
    output logic [BYTES-1:0] be,
    output logic [W-1:0]     bits
);
    logic full;
    always_comb full = !last || (count == '0);

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign be[i] = full || (CW'(i) < count);
        assign bits[8*i +: 8] = {8{be[i]}};
    end
endmodule

// File: rtl/stream_crypt_path.sv
module stream_crypt_path
    import scp_pkg::*;
#(
    parameter int BYTES = 16,
    localparam int W = BYTES * 8,
    localparam int CW = $clog2(BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_decrypt,
    input  logic [W-1:0]     in_data,
    input  logic [CW-1:0]    in_count,
    input  logic             in_last,
    input  logic [W-1:0]     st_w1,
    input  logic [W-1:0]     st_w2,
    input  logic [W-1:0]     st_w3,
    input  logic [W-1:0]     st_w4,
    input  logic             upd_ready,
    output logic             upd_strobe,
    output logic [W-1:0]     upd_word,
    output logic             res_valid,
    output logic [W-1:0]     res_data,
    output logic [BYTES-1:0] res_be,
    output logic             res_first,
    output logic             res_last
);
    msg_state_t state_q, state_d;
    logic [W-1:0]     ks, mask_bits, xored, plain;
    logic [BYTES-1:0] be;
    logic             accept;

    scp_keystream #(.W(W)) u_ks (
        .w1(st_w1), .w2(st_w2), .w3(st_w3), .w4(st_w4), .ks(ks)
    );

    scp_tail_mask #(.BYTES(BYTES)) u_mask (
        .count(in_count), .last(in_last), .be(be), .bits(mask_bits)
    );

    always_comb begin
        accept     = in_valid && upd_ready;
        in_ready   = upd_ready;
        xored      = in_data ^ ks;
        plain      = in_decrypt ? xored : in_data;
        upd_word   = plain & mask_bits;
        upd_strobe = accept;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !in_last) state_d = ST_OPEN;
            ST_OPEN: if (accept && in_last)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_be    <= '0;
            res_first <= 1'b0;
            res_last  <= 1'b0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_data  <= xored & mask_bits;
                res_be    <= be;
                res_first <= (state_q == ST_IDLE);
                res_last  <= in_last;
            end
        end
    end

    logic [W-1:0] res_be_bits;
    for (genvar i = 0; i < BYTES; i++) begin : g_be_exp
        assign res_be_bits[8*i +: 8] = {8{res_be[i]}};
    end

    assert_strobe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_ready |-> !upd_strobe);
    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |=> res_valid);
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_strobe |=> !res_valid);
    assert_mask_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_be[0] && (((res_be + 1'b1) & res_be) == '0)));
    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_data & ~res_be_bits) == '0));
    assert_full_body_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_last) |-> (res_be == {BYTES{1'b1}}));
    assert_first_after_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_last) |=> (!res_valid || res_first));
endmodule

// File: tb/sim_stream_crypt_path.sv
`timescale 1ns/1ps
module sim_stream_crypt_path;
    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_decrypt = 1'b0, in_last = 1'b0, upd_ready = 1'b1;
    logic [127:0] in_data = '0, st_w1 = '0, st_w2 = '0, st_w3 = '0, st_w4 = '0;
    logic [3:0] in_count = '0;
    logic in_ready, upd_strobe, res_valid, res_first, res_last;
    logic [127:0] upd_word, res_data;
    logic [15:0] res_be;

    int checks = 0, errors = 0;
    bit finished = 0;
    bit open_msg = 0;

    always #10 clk = ~clk;

    stream_crypt_path u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_decrypt(in_decrypt), .in_data(in_data), .in_count(in_count),
        .in_last(in_last), .st_w1(st_w1), .st_w2(st_w2), .st_w3(st_w3),
        .st_w4(st_w4), .upd_ready(upd_ready), .upd_strobe(upd_strobe),
        .upd_word(upd_word), .res_valid(res_valid), .res_data(res_data),
        .res_be(res_be), .res_first(res_first), .res_last(res_last)
    );

    function automatic logic [15:0] exp_be(input logic [3:0] c, input logic l);
        logic [15:0] b;
        for (int i = 0; i < 16; i++) b[i] = (!l || c == 0 || i < c);
        return b;
    endfunction

    function automatic logic [127:0] expand(input logic [15:0] b);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = {8{b[i]}};
        return r;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic blk(input logic m, input logic [127:0] d, input logic [3:0] c,
                       input logic l, input logic rdy, input string tag);
        logic [127:0] z, mk, pl, eu, er;
        logic [15:0] eb;
        @(negedge clk);
        st_w1 = rnd128(); st_w2 = rnd128(); st_w3 = rnd128(); st_w4 = rnd128();
        in_valid = 1'b1; in_decrypt = m; in_data = d; in_count = c; in_last = l;
        upd_ready = rdy;
        z  = st_w1 ^ st_w4 ^ (st_w2 & st_w3);
        eb = exp_be(c, l);
        mk = expand(eb);
        pl = m ? (d ^ z) : d;
        eu = pl & mk;
        er = (d ^ z) & mk;
        #2;
        chk(in_ready == rdy, "R10 in_ready", 128'(in_ready), 128'(rdy));
        chk(upd_strobe == rdy, "R10 upd_strobe", 128'(upd_strobe), 128'(rdy));
        if (rdy) chk(upd_word == eu, m ? {"R5 ", tag} : {"R3 ", tag}, upd_word, eu);
        @(negedge clk);
        in_valid = 1'b0;
        chk(res_valid == rdy, "R11 res_valid", 128'(res_valid), 128'(rdy));
        if (rdy) begin
            chk(res_data == er, m ? {"R4 ", tag} : {"R2 ", tag}, res_data, er);
            chk(res_be == eb, {"R7 ", tag}, 128'(res_be), 128'(eb));
            chk(res_first == !open_msg, "R12 first", 128'(res_first), 128'(!open_msg));
            chk(res_last == l, "R12 last", 128'(res_last), 128'(l));
            open_msg = !l;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R13 reset valid", 128'(res_valid), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R13 idle valid", 128'(res_valid), 128'd0);
        // R1: zero plaintext exposes the keystream
        blk(1'b0, '0, 4'd0, 1'b0, 1'b1, "R1 keystream");
        // R9: count on non-last word ignored
        blk(1'b0, rnd128(), 4'd5, 1'b0, 1'b1, "R9 body count");
        // R8: last with count 0 is full
        blk(1'b1, rnd128(), 4'd0, 1'b1, 1'b1, "R8 full last");
        // R6 boundaries 1 and 15, both modes
        blk(1'b0, rnd128(), 4'd1, 1'b1, 1'b1, "R6 enc n1");
        blk(1'b1, rnd128(), 4'd15, 1'b1, 1'b1, "R6 dec n15");
        blk(1'b1, rnd128(), 4'd1, 1'b1, 1'b1, "R6 dec n1");
        // R10/R11: updater not ready
        blk(1'b0, rnd128(), 4'd0, 1'b0, 1'b0, "R10 stall");
        blk(1'b0, rnd128(), 4'd0, 1'b0, 1'b1, "R12 open");
        blk(1'b1, rnd128(), 4'd7, 1'b1, 1'b1, "R12 close");
        for (int k = 0; k < 400; k++) begin
            blk(1'($urandom), rnd128(), 4'($urandom), ($urandom % 4) == 0,
                ($urandom % 5) != 0, "random");
        end
        @(negedge clk);
        chk(res_valid == 1'b0, "R11 quiet", 128'(res_valid), 128'd0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule